// File: doc/BRIEF.md
# Timestamp Counter Event Unit

This block keeps a 32-bit free-running time count that advances once per tick of a reference clock chosen by a select input from several candidate tick lines. Every notable moment is turned into a timestamped record and queued in a small event queue that a host drains through a write-only register port. The notable moments are the count wrapping to zero, the count crossing into its upper half, a software request, a rising edge on any of the external push inputs (a one-pulse-per-second strobe, for example) and the count reaching a host-programmed compare value.

The compare match also raises a timing output pulse that lasts a programmable number of reference ticks. Software keeps the bits above 32 itself. When a record carries a wrap event, software tells a late-arriving stamp apart by looking at its top bit until the half-crossing record shows up. Each record carries a 4-bit kind, a 4-bit source number and the 32-bit stamp. The queue head is always visible on the outputs.

Top module: `tstamp_event_unit`

## Requirements
- R1: The count goes up by exactly one on each cycle where the tick line chosen by `ref_sel` is high, and tick lines that are not selected have no effect. A write to address 5 loads `wr_data` into the count. A load wins over a tick in the same cycle and raises no wrap, half or compare event.
- R2: A tick that takes the count from 0xFFFF_FFFF to 0 queues a record with kind 4, source 0 and stamp 0.
- R3: A tick that takes the count from 0x7FFF_FFFF to 0x8000_0000 queues a record with kind 5, source 0 and stamp 0x8000_0000.
- R4: A write to address 2 queues a record with kind 3, source 0, and as stamp the count held in the cycle of the write.
- R5: Each input of `hw_push` passes through a two-flop synchronizer. A rising edge on input i queues exactly one record with kind 1, source i+1, and as stamp the count when the edge is detected. A level that is held high queues nothing further.
- R6: A write to address 0 sets the compare value, which is all ones after reset. A tick that brings the count to that value queues a record with kind 2, source 0 and the compare value as stamp. The same tick raises `cmp_pulse` for the number of following ticks written at address 1 (default 4).
- R7: Records raised in the same cycle are queued in this order: push inputs (lower index first), then compare, then software request, then wrap, then half-crossing.
- R8: The queue holds 16 records. Its head is shown on `ev_valid`, `ev_kind`, `ev_src` and `ev_stamp`, and its fill level on `ev_level`. A write to address 3 removes the head. That write has no effect on an empty queue.
- R9: A record that finds the queue full is dropped, and `ovf_flag` is set and stays set. A write to address 4 clears it, unless a new loss occurs in the same cycle.
- R10: After reset the count is 0, the queue is empty, and `ovf_flag` and `cmp_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 4 | Candidate reference tick strobes |
| ref_sel | input | 2 | Selects which tick line advances the count |
| hw_push | input | 6 | Asynchronous external push inputs |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 32 | Host write data |
| ts_count | output | 32 | Current time count |
| ev_valid | output | 1 | Queue is not empty |
| ev_kind | output | 4 | Kind of the head record |
| ev_src | output | 4 | Source number of the head record |
| ev_stamp | output | 32 | Stamp of the head record |
| ev_level | output | 5 | Number of queued records |
| ovf_flag | output | 1 | Sticky record-loss flag |
| cmp_pulse | output | 1 | Compare-triggered timing pulse |

## Verification
The in-line assertions watch these relations on every cycle:
- the count holds still without a chosen tick or a load,
- the stamp value that follows a wrap or a half crossing,
- that the pulse only starts when the count equals the compare value,
- that a synchronized push edge lasts one cycle,
- that the loss flag is sticky,
- that a full or empty queue keeps its level at the bounds.

The bench scenarios cover the rest: the record contents, the drain order when several events share a cycle, the pulse length counted in ticks, and the loss and clear sequence when the queue fills.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int TS_W   = 32;
    localparam int KIND_W = 4;
    localparam int SRC_W  = 4;

    typedef enum logic [KIND_W-1:0] {
        EV_NONE    = 4'd0,
        EV_HWPUSH  = 4'd1,
        EV_COMPARE = 4'd2,
        EV_SWPUSH  = 4'd3,
        EV_WRAP    = 4'd4,
        EV_HALF    = 4'd5
    } ev_kind_e;

    typedef enum logic [2:0] {
        RA_CMP    = 3'd0,
        RA_WIDTH  = 3'd1,
        RA_SWPUSH = 3'd2,
        RA_POP    = 3'd3,
        RA_CLROVF = 3'd4,
        RA_LOAD   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        ev_kind_e          kind;
        logic [SRC_W-1:0]  src;
        logic [TS_W-1:0]   stamp;
    } ev_rec_t;

    function automatic ev_rec_t mk_ev(input ev_kind_e k, input logic [SRC_W-1:0] s,
                                      input logic [TS_W-1:0] t);
        ev_rec_t r;
        r.kind  = k;
        r.src   = s;
        r.stamp = t;
        return r;
    endfunction

endpackage

// File: rtl/tsu_counter.sv
module tsu_counter
    import tsu_pkg::*;
#(
    parameter int NREF      = 4,
    parameter int PW_W      = 8,
    parameter int PW_RESET  = 4,
    localparam int SEL_W    = (NREF > 1) ? $clog2(NREF) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREF-1:0]   tick,
    input  logic [SEL_W-1:0]  sel,
    input  logic              load_en,
    input  logic              cmp_we,
    input  logic              width_we,
    input  logic [TS_W-1:0]   wdata,
    output logic [TS_W-1:0]   cnt,
    output logic [TS_W-1:0]   cnt_nxt,
    output logic              wrap_hit,
    output logic              half_hit,
    output logic              cmp_hit,
    output logic              pulse
);

    localparam logic [TS_W-1:0] HALF_EDGE = {1'b0, {(TS_W-1){1'b1}}};

    logic [TS_W-1:0] cmp_q;
    logic [PW_W-1:0] width_q;
    logic [PW_W-1:0] pulse_left;
    logic            tick_g;

    assign tick_g   = tick[sel] && !load_en;
    assign cnt_nxt  = cnt + 1'b1;
    assign wrap_hit = tick_g && (cnt == '1);
    assign half_hit = tick_g && (cnt == HALF_EDGE);
    assign cmp_hit  = tick_g && (cnt_nxt == cmp_q);
    assign pulse    = (pulse_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            cmp_q      <= '1;
            width_q    <= PW_W'(PW_RESET);
            pulse_left <= '0;
        end else begin
            if (load_en)       cnt <= wdata;
            else if (tick_g)   cnt <= cnt_nxt;
            if (cmp_we)   cmp_q   <= wdata;
            if (width_we) width_q <= wdata[PW_W-1:0];
            if (cmp_hit)
                pulse_left <= width_q;
            else if (tick_g && pulse)
                pulse_left <= pulse_left - 1'b1;
        end
    end

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick[sel] && !load_en) |=> $stable(cnt));
    // R2
    wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_hit |=> (cnt == '0));
    // R3
    half_value_chk: assert property (@(posedge clk) disable iff (rst)
        half_hit |=> (cnt == ~HALF_EDGE));
    // R6
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> (cnt == cmp_q));

endmodule

// File: rtl/tsu_push_sync.sv
module tsu_push_sync #(
    parameter int NHW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NHW-1:0] push_in,
    output logic [NHW-1:0] push_edge
);

    for (genvar g = 0; g < NHW; g++) begin : g_lane
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= push_in[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign push_edge[g] = s2 && !s3;

        // R5
        edge_single_chk: assert property (@(posedge clk) disable iff (rst)
            push_edge[g] |=> !push_edge[g]);
    end

endmodule

// File: rtl/tsu_stager.sv
module tsu_stager
    import tsu_pkg::*;
#(
    parameter int NHW  = 6,
    localparam int NSLOT = NHW + 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NHW-1:0]  hw_edge,
    input  logic            cmp_hit,
    input  logic            sw_hit,
    input  logic            wrap_hit,
    input  logic            half_hit,
    input  logic [TS_W-1:0] cnt,
    input  logic [TS_W-1:0] cnt_nxt,
    input  logic            fifo_full,
    input  logic            clr_ovf,
    output logic            push,
    output ev_rec_t         push_rec,
    output logic            ovf
);

    logic [NSLOT-1:0] new_ev, pend, pick_oh, lost;
    ev_rec_t          new_rec [NSLOT];
    ev_rec_t          slot_q  [NSLOT];
    logic             pick_any;
    logic             loss;

    always_comb begin
        for (int i = 0; i < NHW; i++) begin
            new_ev[i]  = hw_edge[i];
            new_rec[i] = mk_ev(EV_HWPUSH, SRC_W'(i + 1), cnt);
        end
        new_ev[NHW]    = cmp_hit;
        new_rec[NHW]   = mk_ev(EV_COMPARE, '0, cnt_nxt);
        new_ev[NHW+1]  = sw_hit;
        new_rec[NHW+1] = mk_ev(EV_SWPUSH, '0, cnt);
        new_ev[NHW+2]  = wrap_hit;
        new_rec[NHW+2] = mk_ev(EV_WRAP, '0, cnt_nxt);
        new_ev[NHW+3]  = half_hit;
        new_rec[NHW+3] = mk_ev(EV_HALF, '0, cnt_nxt);
    end

    always_comb begin
        pick_oh  = '0;
        pick_any = 1'b0;
        push_rec = slot_q[0];
        for (int i = 0; i < NSLOT; i++) begin
            if (pend[i] && !pick_any) begin
                pick_oh[i] = 1'b1;
                pick_any   = 1'b1;
                push_rec   = slot_q[i];
            end
        end
    end

    assign push = pick_any && !fifo_full;
    assign lost = new_ev & pend & ~pick_oh;
    assign loss = (|lost) || (pick_any && fifo_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ovf  <= 1'b0;
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (new_ev[i]) begin
                    pend[i]   <= 1'b1;
                    slot_q[i] <= new_rec[i];
                end else if (pick_oh[i]) begin
                    pend[i]   <= 1'b0;
                end
            end
            if (loss)         ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
        end
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);

endmodule

// File: rtl/tsu_fifo.sv
module tsu_fifo
    import tsu_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  ev_rec_t  push_rec,
    input  logic     pop,
    output logic     full,
    output logic     nonempty,
    output ev_rec_t  head,
    output logic [AW:0] level
);

    ev_rec_t       mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full     = (level == (AW+1)'(DEPTH));
    assign nonempty = (level != '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (!nonempty && pop && !push) |=> !nonempty);

endmodule

// File: rtl/tstamp_event_unit.sv
module tstamp_event_unit
    import tsu_pkg::*;
#(
    parameter int NREF     = 4,
    parameter int NHW      = 6,
    parameter int DEPTH    = 16,
    parameter int PW_W     = 8,
    parameter int PW_RESET = 4,
    localparam int SEL_W   = (NREF > 1) ? $clog2(NREF) : 1,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREF-1:0]   ref_tick,
    input  logic [SEL_W-1:0]  ref_sel,
    input  logic [NHW-1:0]    hw_push,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [TS_W-1:0]   wr_data,
    output logic [TS_W-1:0]   ts_count,
    output logic              ev_valid,
    output logic [KIND_W-1:0] ev_kind,
    output logic [SRC_W-1:0]  ev_src,
    output logic [TS_W-1:0]   ev_stamp,
    output logic [AW:0]       ev_level,
    output logic              ovf_flag,
    output logic              cmp_pulse
);

    logic [TS_W-1:0] cnt_nxt;
    logic            wrap_hit, half_hit, cmp_hit;
    logic [NHW-1:0]  hw_edge;
    logic            fifo_push, fifo_full;
    ev_rec_t         push_rec, head;
    logic            we_cmp, we_width, we_sw, we_pop, we_clr, we_load;

    assign we_cmp   = wr_en && (wr_addr == RA_CMP);
    assign we_width = wr_en && (wr_addr == RA_WIDTH);
    assign we_sw    = wr_en && (wr_addr == RA_SWPUSH);
    assign we_pop   = wr_en && (wr_addr == RA_POP);
    assign we_clr   = wr_en && (wr_addr == RA_CLROVF);
    assign we_load  = wr_en && (wr_addr == RA_LOAD);

    tsu_counter #(.NREF(NREF), .PW_W(PW_W), .PW_RESET(PW_RESET)) u_counter (
        .clk(clk), .rst(rst), .tick(ref_tick), .sel(ref_sel),
        .load_en(we_load), .cmp_we(we_cmp), .width_we(we_width), .wdata(wr_data),
        .cnt(ts_count), .cnt_nxt(cnt_nxt), .wrap_hit(wrap_hit), .half_hit(half_hit),
        .cmp_hit(cmp_hit), .pulse(cmp_pulse)
    );

    tsu_push_sync #(.NHW(NHW)) u_sync (
        .clk(clk), .rst(rst), .push_in(hw_push), .push_edge(hw_edge)
    );

    tsu_stager #(.NHW(NHW)) u_stager (
        .clk(clk), .rst(rst), .hw_edge(hw_edge), .cmp_hit(cmp_hit), .sw_hit(we_sw),
        .wrap_hit(wrap_hit), .half_hit(half_hit), .cnt(ts_count), .cnt_nxt(cnt_nxt),
        .fifo_full(fifo_full), .clr_ovf(we_clr), .push(fifo_push),
        .push_rec(push_rec), .ovf(ovf_flag)
    );

    tsu_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(fifo_push), .push_rec(push_rec), .pop(we_pop),
        .full(fifo_full), .nonempty(ev_valid), .head(head), .level(ev_level)
    );

    assign ev_kind  = head.kind;
    assign ev_src   = head.src;
    assign ev_stamp = head.stamp;

endmodule

// File: tb/tstamp_event_unit_bench.sv
module tstamp_event_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ref_tick = '0;
    logic [1:0]  ref_sel = 2'd1;
    logic [5:0]  hw_push = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ts_count, ev_stamp;
    logic        ev_valid, ovf_flag, cmp_pulse;
    logic [3:0]  ev_kind, ev_src;
    logic [4:0]  ev_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tstamp_event_unit u_tstamp_event_unit (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .ref_sel(ref_sel), .hw_push(hw_push),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ts_count(ts_count),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_src(ev_src), .ev_stamp(ev_stamp),
        .ev_level(ev_level), .ovf_flag(ovf_flag), .cmp_pulse(cmp_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick_sel(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick[1] = 1'b1;
            @(negedge clk); ref_tick[1] = 1'b0;
        end
    endtask

    task automatic expect_head(input string tag, input logic [3:0] k,
                               input logic [3:0] s, input logic [31:0] t);
        check({tag, " valid"}, 32'(ev_valid), 32'd1);
        check({tag, " kind"}, 32'(ev_kind), 32'(k));
        check({tag, " src"}, 32'(ev_src), 32'(s));
        check({tag, " stamp"}, ev_stamp, t);
        host_wr(3'd3, '0);
    endtask

    task automatic t_reset;
        check("R10 count", ts_count, 32'd0);
        check("R10 valid", 32'(ev_valid), 32'd0);
        check("R10 level", 32'(ev_level), 32'd0);
        check("R10 ovf", 32'(ovf_flag), 32'd0);
        check("R10 pulse", 32'(cmp_pulse), 32'd0);
    endtask

    task automatic t_count;
        tick_sel(5);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ref_tick[0] = 1'b1; ref_tick[2] = 1'b1;
            @(negedge clk); ref_tick = '0;
        end
        check("R1 count after 5 selected ticks", ts_count, 32'd5);
        host_wr(3'd5, 32'h0000_1234);
        check("R1 load", ts_count, 32'h0000_1234);
        check("R1 load no event", 32'(ev_level), 32'd0);
    endtask

    task automatic t_swpush;
        host_wr(3'd2, '0);
        idle(3);
        expect_head("R4 sw push", 4'd3, 4'd0, 32'h0000_1234);
    endtask

    task automatic t_hwpush;
        host_wr(3'd5, 32'hABCD_0000);
        @(negedge clk); hw_push[2] = 1'b1;
        idle(10);
        check("R5 single record for held level", 32'(ev_level), 32'd1);
        expect_head("R5 hw push 2", 4'd1, 4'd3, 32'hABCD_0000);
        hw_push = '0;
        idle(4);
        @(negedge clk); hw_push[5] = 1'b1; hw_push[0] = 1'b1;
        idle(10);
        check("R7 two hw records", 32'(ev_level), 32'd2);
        expect_head("R7 hw lower index first", 4'd1, 4'd1, 32'hABCD_0000);
        expect_head("R7 hw higher index next", 4'd1, 4'd6, 32'hABCD_0000);
        hw_push = '0;
        idle(4);
    endtask

    task automatic t_wraps;
        host_wr(3'd5, 32'h7FFF_FFFF);
        tick_sel(1);
        idle(3);
        expect_head("R3 half crossing", 4'd5, 4'd0, 32'h8000_0000);
        host_wr(3'd5, 32'hFFFF_FFFF);
        tick_sel(1);
        idle(3);
        check("R2 count wrapped", ts_count, 32'd0);
        check("R2 one record", 32'(ev_level), 32'd1);
        expect_head("R2 wrap", 4'd4, 4'd0, 32'd0);
    endtask

    task automatic t_compare;
        host_wr(3'd0, 32'h0000_0100);
        host_wr(3'd5, 32'h0000_00FF);
        tick_sel(1);
        check("R6 pulse at match", 32'(cmp_pulse), 32'd1);
        tick_sel(3);
        check("R6 pulse after 3 ticks", 32'(cmp_pulse), 32'd1);
        tick_sel(1);
        check("R6 pulse ends after 4 ticks", 32'(cmp_pulse), 32'd0);
        expect_head("R6 compare", 4'd2, 4'd0, 32'h0000_0100);
        host_wr(3'd1, 32'd2);
        host_wr(3'd5, 32'h0000_00FF);
        tick_sel(1);
        tick_sel(1);
        check("R6 width 2 still high", 32'(cmp_pulse), 32'd1);
        tick_sel(1);
        check("R6 width 2 ends", 32'(cmp_pulse), 32'd0);
        host_wr(3'd3, '0);
    endtask

    task automatic t_priority;
        host_wr(3'd0, 32'h0000_0000);
        host_wr(3'd5, 32'hFFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; ref_tick[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ref_tick = '0;
        idle(6);
        check("R7 three records", 32'(ev_level), 32'd3);
        expect_head("R7 compare first", 4'd2, 4'd0, 32'd0);
        expect_head("R7 sw second", 4'd3, 4'd0, 32'hFFFF_FFFF);
        expect_head("R7 wrap third", 4'd4, 4'd0, 32'd0);
        host_wr(3'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow;
        host_wr(3'd5, 32'h0000_0500);
        for (int i = 0; i < 17; i++) host_wr(3'd2, '0);
        idle(3);
        check("R8 level full", 32'(ev_level), 32'd16);
        check("R9 ovf set", 32'(ovf_flag), 32'd1);
        idle(5);
        check("R9 ovf sticky", 32'(ovf_flag), 32'd1);
        host_wr(3'd4, '0);
        check("R9 ovf cleared", 32'(ovf_flag), 32'd0);
        for (int i = 0; i < 16; i++) host_wr(3'd3, '0);
        check("R8 drained", 32'(ev_valid), 32'd0);
        host_wr(3'd3, '0);
        check("R8 pop on empty", 32'(ev_level), 32'd0);
        host_wr(3'd5, 32'h0000_0777);
        host_wr(3'd2, '0);
        idle(3);
        check("R8 level after empty pop", 32'(ev_level), 32'd1);
        expect_head("R8 record after empty pop", 4'd3, 4'd0, 32'h0000_0777);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_swpush();
        t_hwpush();
        t_wraps();
        t_compare();
        t_priority();
        t_overflow();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule